// File: doc/BRIEF.md
# Audio Frame Sync Searcher

This block finds the start of each audio frame in a serial coded bitstream and holds on to it. Bits arrive one per clock when `bit_vld` is high. An optional strobe, `sync_in`, can mark positions in the stream. A 2-bit mode input picks how a first candidate is found. The choices are the strobe alone, a short pattern that must start on a byte boundary set by the strobe, a longer pattern at any bit offset, or two longer patterns searched in turn with a timeout between them.

After a candidate is found, the block waits for more frame starts before it declares lock. Each of these must fall exactly `frame_len` valid bits after the previous one; a header parser outside the block supplies `frame_len`. The number of extra frames depends on two flags: whether the stream carries CRC protection and whether it uses a free-format bit rate. While there is no lock the block asks for the audio output to be muted. When lock is held it pulses `frame_start` once per confirmed frame. A missing frame start sends it back to the search.

Top module: `afs_sync_search`

## Requirements
- R1: After reset `locked` is 0, `mute` is 1, `frame_start` is 0, and the dual-pattern search begins with the first pattern.
- R2: With mode 2'b11, a valid bit that arrives with a pending or current rising edge of `sync_in` is a frame-start candidate, and the bit contents are never inspected.
- R3: With mode 2'b10, a candidate is the 14-bit pattern 111111111111X1 (oldest bit first, X any value) whose first bit sits at byte offset 0. Byte offsets are counted in valid bits, and offset 0 is the valid bit taken with a `sync_in` rising edge. No candidate is possible before the first such edge, and a pattern at any other offset is rejected.
- R4: With mode 2'b01, a candidate is the 15-bit pattern 111111111111X10 ending on any valid bit, and `sync_in` has no effect.
- R5: With mode 2'b00, the search starts with 111111111111X10 and changes to 0111111111111X1 (and back again) after every `TMO_BITS` valid bits spent searching. The counter restarts at each change and whenever searching resumes. A match on the bit that ends the window is still judged against the old pattern.
- R6: The number of further frame starts required before lock is 0 when `crc_on`=1 and `free_fmt`=0, 1 when both are 1, 1 when both are 0, and 2 when `crc_on`=0 and `free_fmt`=1.
- R7: Each further frame start is accepted only if it is detected on exactly the `frame_len`-th valid bit after the previous one. Otherwise verification fails and searching resumes from the following bit.
- R8: `mute` is high whenever `locked` is low, and `locked` rises on the valid bit that completes verification.
- R9: While locked, a frame start missing at its expected bit clears `locked`, raises `mute` and resumes searching.
- R10: `frame_start` is a one-cycle pulse after each valid bit on which a frame start is confirmed with the block ending in lock, and is low otherwise.
- R11: Clocks with `bit_vld` low change nothing: bit contents, `sync_in` edges and the frame spacing count are all unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | `bit_in` carries a stream bit this cycle |
| bit_in | input | 1 | Serial coded stream bit |
| sync_in | input | 1 | External sync strobe; rising edges count |
| mode | input | 2 | Search mode (00 dual, 01 long pattern, 10 byte-aligned, 11 strobe) |
| crc_on | input | 1 | Stream carries CRC protection |
| free_fmt | input | 1 | Stream uses a free-format bit rate |
| frame_len | input | LEN_W | Expected frame length in valid bits |
| locked | output | 1 | Frame lock established |
| frame_start | output | 1 | Pulse for each confirmed frame start |
| mute | output | 1 | Request to mute audio output |

## Verification
In dual-pattern mode, the pattern timeout and a pattern match can fall on the same valid bit. The bench places the end of a first-pattern match exactly on the `TMO_BITS`-th valid bit after reset and expects lock, because the match is judged before the change. A run one bit longer must not lock, and a second-pattern match that follows must lock one bit earlier than the first pattern could.

// File: rtl/afs_pkg.sv
package afs_pkg;

   typedef enum logic [1:0] {
      MD_DUAL   = 2'b00,
      MD_LONG   = 2'b01,
      MD_BYTE   = 2'b10,
      MD_STROBE = 2'b11
   } afs_mode_e;

   typedef enum logic [1:0] {
      ST_HUNT  = 2'd0,
      ST_CHECK = 2'd1,
      ST_LOCK  = 2'd2
   } afs_state_e;

   localparam int WIN_BITS   = 15;
   localparam int SHORT_BITS = 14;

   // further frames required before lock
   function automatic logic [1:0] verify_depth(input logic crc, input logic free);
      case ({crc, free})
         2'b10:   return 2'd0;
         2'b11:   return 2'd1;
         2'b00:   return 2'd1;
         default: return 2'd2;
      endcase
   endfunction

endpackage

// File: rtl/afs_bit_window.sv
module afs_bit_window #(
   parameter int WIN = 15
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bit_vld,
   input  logic           bit_in,
   input  logic           sync_in,
   output logic [WIN-1:0] win,
   output logic           sync_hit,
   output logic [2:0]     byte_pos,
   output logic           aligned
);

   logic [WIN-2:0] hist_q;
   logic           sync_q;
   logic           pend_q;
   logic [2:0]     bpos_q;
   logic           algn_q;
   logic           rise;

   assign rise     = sync_in & ~sync_q;
   assign sync_hit = pend_q | rise;
   assign win      = {hist_q, bit_in};
   assign byte_pos = sync_hit ? 3'd0 : bpos_q + 3'd1;
   assign aligned  = sync_hit | algn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
         sync_q <= 1'b0;
         pend_q <= 1'b0;
         bpos_q <= 3'd7;
         algn_q <= 1'b0;
      end else begin
         sync_q <= sync_in;
         if (bit_vld) begin
            hist_q <= win[WIN-2:0];
            pend_q <= 1'b0;
            bpos_q <= byte_pos;
            if (sync_hit) algn_q <= 1'b1;
         end else if (rise) begin
            pend_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/afs_pattern_match.sv
module afs_pattern_match
   import afs_pkg::*;
(
   input  logic [WIN_BITS-1:0] win,
   input  afs_mode_e           mode,
   input  logic                pat_b,
   input  logic                sync_hit,
   input  logic [2:0]          byte_pos,
   input  logic                aligned,
   output logic                cand
);

   // index 0: long pattern, 1: alternate pattern, 2: short byte pattern
   localparam int NPAT = 3;
   localparam logic [NPAT-1:0][WIN_BITS-1:0] PVAL = {
      15'b0_111111111111_0_1,
      15'b0_111111111111_0_1,
      15'b111111111111_0_10
   };
   localparam logic [NPAT-1:0][WIN_BITS-1:0] PCARE = {
      15'b0_111111111111_0_1,
      15'b1_111111111111_0_1,
      15'b111111111111_0_11
   };
   localparam logic [2:0] SHORT_END = 3'((SHORT_BITS - 1) % 8);

   logic [NPAT-1:0] hit;

   for (genvar g = 0; g < NPAT; g++) begin : g_pat
      assign hit[g] = ((win ^ PVAL[g]) & PCARE[g]) == '0;
   end

   always_comb begin
      unique case (mode)
         MD_STROBE: cand = sync_hit;
         MD_BYTE:   cand = hit[2] & aligned & (byte_pos == SHORT_END);
         MD_LONG:   cand = hit[0];
         default:   cand = pat_b ? hit[1] : hit[0];
      endcase
   end

endmodule

// File: rtl/afs_verify_fsm.sv
module afs_verify_fsm
   import afs_pkg::*;
#(
   parameter int LEN_W    = 16,
   parameter int TMO_BITS = 27700
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_vld,
   input  logic             cand,
   input  logic             dual,
   input  logic             crc_on,
   input  logic             free_fmt,
   input  logic [LEN_W-1:0] frame_len,
   output logic             locked,
   output logic             frame_start,
   output logic             pat_b
);

   localparam int TMO_W = $clog2(TMO_BITS);
   localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_BITS - 1);

   afs_state_e       st_q;
   logic [1:0]       need_q;
   logic [LEN_W-1:0] dist_q;
   logic [LEN_W-1:0] dist_nx;
   logic [TMO_W-1:0] tmr_q;
   logic             fs_q;
   logic             patb_q;
   logic [1:0]       dep;

   assign dist_nx     = dist_q + 1'b1;
   assign dep         = verify_depth(crc_on, free_fmt);
   assign locked      = (st_q == ST_LOCK);
   assign frame_start = fs_q;
   assign pat_b       = patb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_HUNT;
         need_q <= 2'd0;
         dist_q <= '0;
         tmr_q  <= '0;
         fs_q   <= 1'b0;
         patb_q <= 1'b0;
      end else begin
         fs_q <= 1'b0;
         if (bit_vld) begin
            unique case (st_q)
               ST_HUNT: begin
                  if (cand) begin
                     dist_q <= '0;
                     tmr_q  <= '0;
                     if (dep == 2'd0) begin
                        st_q <= ST_LOCK;
                        fs_q <= 1'b1;
                     end else begin
                        st_q   <= ST_CHECK;
                        need_q <= dep;
                     end
                  end else if (dual) begin
                     if (tmr_q == TMO_LAST) begin
                        tmr_q  <= '0;
                        patb_q <= ~patb_q;
                     end else begin
                        tmr_q <= tmr_q + 1'b1;
                     end
                  end
               end
               default: begin
                  if (dist_nx == frame_len) begin
                     dist_q <= '0;
                     if (!cand) begin
                        st_q  <= ST_HUNT;
                        tmr_q <= '0;
                     end else if (st_q == ST_LOCK || need_q == 2'd1) begin
                        st_q <= ST_LOCK;
                        fs_q <= 1'b1;
                     end else begin
                        need_q <= need_q - 2'd1;
                     end
                  end else begin
                     dist_q <= dist_nx;
                  end
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/afs_sync_search.sv
module afs_sync_search
   import afs_pkg::*;
#(
   parameter int LEN_W    = 16,
   parameter int TMO_BITS = 27700
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_vld,
   input  logic             bit_in,
   input  logic             sync_in,
   input  logic [1:0]       mode,
   input  logic             crc_on,
   input  logic             free_fmt,
   input  logic [LEN_W-1:0] frame_len,
   output logic             locked,
   output logic             frame_start,
   output logic             mute
);

   if (LEN_W < 5) begin : g_bad_len
      $error("LEN_W must hold a frame longer than the sync window");
   end
   if (TMO_BITS < 16) begin : g_bad_tmo
      $error("TMO_BITS must be at least 16");
   end

   logic [WIN_BITS-1:0] win;
   logic                sync_hit;
   logic [2:0]          byte_pos;
   logic                aligned;
   logic                cand;
   logic                pat_b;
   afs_mode_e           md;

   assign md = afs_mode_e'(mode);

   afs_bit_window #(.WIN(WIN_BITS)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_vld  (bit_vld),
      .bit_in   (bit_in),
      .sync_in  (sync_in),
      .win      (win),
      .sync_hit (sync_hit),
      .byte_pos (byte_pos),
      .aligned  (aligned)
   );

   afs_pattern_match u_match (
      .win      (win),
      .mode     (md),
      .pat_b    (pat_b),
      .sync_hit (sync_hit),
      .byte_pos (byte_pos),
      .aligned  (aligned),
      .cand     (cand)
   );

   afs_verify_fsm #(.LEN_W(LEN_W), .TMO_BITS(TMO_BITS)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_vld     (bit_vld),
      .cand        (cand),
      .dual        (md == MD_DUAL),
      .crc_on      (crc_on),
      .free_fmt    (free_fmt),
      .frame_len   (frame_len),
      .locked      (locked),
      .frame_start (frame_start),
      .pat_b       (pat_b)
   );

   assign mute = ~locked;

endmodule

// File: rtl/afs_sync_search_chk.sv
module afs_sync_search_chk (
   input logic clk,
   input logic rst_n,
   input logic bit_vld,
   input logic locked,
   input logic frame_start,
   input logic mute
);

   AST_FS_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> locked) else $error("frame_start outside lock"); // R10

   AST_FS_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> $past(bit_vld)) else $error("frame_start without valid bit"); // R10

   AST_NO_FS_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
      mute |-> !frame_start) else $error("frame_start while muted"); // R8

   AST_MUTE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |-> mute) else $error("unmuted without lock"); // R8

   AST_LOCK_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(bit_vld)) else $error("lock rose on idle cycle"); // R11

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_vld |=> $stable(locked)) else $error("lock moved on idle cycle"); // R11

   AST_LOSS_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> mute) else $error("lost lock without mute"); // R9

endmodule

bind afs_sync_search afs_sync_search_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bit_vld     (bit_vld),
   .locked      (locked),
   .frame_start (frame_start),
   .mute        (mute)
);

// File: tb/afs_sync_search_test.sv
module afs_sync_search_test;

   localparam int CLK_PERIOD = 10;
   localparam int LEN_W      = 16;
   localparam int TMO        = 100;
   localparam int FLEN       = 40;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             bit_vld = 1'b0;
   logic             bit_in = 1'b0;
   logic             sync_in = 1'b0;
   logic [1:0]       mode = 2'b01;
   logic             crc_on = 1'b1;
   logic             free_fmt = 1'b0;
   logic [LEN_W-1:0] frame_len = LEN_W'(FLEN);
   logic             locked, frame_start, mute;

   int checks = 0;
   int fails  = 0;
   logic done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   afs_sync_search #(.LEN_W(LEN_W), .TMO_BITS(TMO)) uut (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
      .sync_in(sync_in), .mode(mode), .crc_on(crc_on), .free_fmt(free_fmt),
      .frame_len(frame_len), .locked(locked), .frame_start(frame_start),
      .mute(mute)
   );

   task automatic chk(input logic act, input logic exp, input string tag, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
      end
   endtask

   task automatic do_reset(input logic [1:0] m, input logic crc, input logic free);
      bit_vld = 1'b0; bit_in = 1'b0; sync_in = 1'b0;
      mode = m; crc_on = crc; free_fmt = free;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic send_bit(input logic b, input logic s);
      bit_in = b; sync_in = s; bit_vld = 1'b1;
      @(negedge clk);
      sync_in = 1'b0;
   endtask

   task automatic zeros(input int n);
      for (int i = 0; i < n; i++) send_bit(1'b0, 1'b0);
   endtask

   // long pattern 111111111111X10, X sent as 0
   function automatic logic pat_a(input int i);
      return (i < 12) || (i == 13);
   endfunction

   // short pattern 111111111111X1, X sent as 0
   function automatic logic pat_s(input int i);
      return (i < 12) || (i == 13);
   endfunction

   task automatic send_a(input int nbits);
      for (int i = 0; i < nbits; i++) send_bit(pat_a(i), 1'b0);
   endtask

   task automatic frame_a();
      send_a(15);
      zeros(FLEN - 15);
   endtask

   task automatic t_reset();
      do_reset(2'b00, 1'b1, 1'b0);
      chk(locked, 1'b0, "R1", "locked after reset");
      chk(mute, 1'b1, "R1", "mute after reset");
      chk(frame_start, 1'b0, "R1", "frame_start after reset");
      // first pattern active: long pattern locks at its 15th bit, not earlier
      zeros(3);
      send_a(14);
      chk(locked, 1'b0, "R1", "alternate pattern not active at start");
      send_a_tail();
      chk(locked, 1'b1, "R1", "first pattern active at start");
   endtask

   task automatic send_a_tail();
      send_bit(1'b0, 1'b0);
   endtask

   task automatic t_long_mode();
      do_reset(2'b01, 1'b1, 1'b0);
      for (int i = 0; i < 10; i++) send_bit(1'b0, i[0]);
      chk(locked, 1'b0, "R4", "sync strobe ignored");
      send_a(14);
      chk(mute, 1'b1, "R8", "mute before pattern ends");
      send_a_tail();
      chk(locked, 1'b1, "R4", "pattern at arbitrary offset locks");
      chk(mute, 1'b0, "R8", "mute drops on lock");
      chk(frame_start, 1'b1, "R10", "pulse on lock");
      zeros(1);
      chk(frame_start, 1'b0, "R10", "pulse lasts one cycle");
   endtask

   task automatic t_depth(input logic crc, input logic free, input int d);
      do_reset(2'b01, crc, free);
      zeros(2);
      for (int k = 0; k <= d; k++) begin
         send_a(15);
         chk(locked, logic'(k == d), "R6", $sformatf("lock after frame %0d (crc %0b free %0b)", k, crc, free));
         if (k < d) chk(mute, 1'b1, "R8", "mute during verification");
         zeros(FLEN - 15);
      end
   endtask

   task automatic t_verify_fail();
      do_reset(2'b01, 1'b0, 1'b0);
      zeros(2);
      frame_a();
      zeros(15);
      chk(locked, 1'b0, "R7", "missing second frame start not locked");
      zeros(5);
      send_a(15);
      chk(locked, 1'b0, "R7", "search restarted: new candidate only");
      zeros(FLEN - 15);
      send_a(15);
      chk(locked, 1'b1, "R7", "lock after restarted verification");
      // late by one bit while locked
      zeros(FLEN - 15 + 1);
      send_a(14);
      chk(locked, 1'b0, "R7", "frame start one bit late rejected");
   endtask

   task automatic t_loss();
      do_reset(2'b01, 1'b1, 1'b0);
      zeros(1);
      frame_a();
      zeros(14);
      chk(locked, 1'b1, "R9", "still locked before expected bit");
      zeros(1);
      chk(locked, 1'b0, "R9", "lock lost at missing start");
      chk(mute, 1'b1, "R9", "mute on loss of lock");
   endtask

   task automatic t_idle();
      do_reset(2'b01, 1'b1, 1'b0);
      zeros(1);
      send_a(15);
      zeros(10);
      bit_vld = 1'b0;
      for (int i = 0; i < 12; i++) begin
         bit_in = 1'b1; sync_in = i[0];
         @(negedge clk);
      end
      sync_in = 1'b0;
      chk(locked, 1'b1, "R11", "idle cycles keep lock");
      chk(frame_start, 1'b0, "R11", "no pulse on idle cycles");
      zeros(FLEN - 15 - 10);
      send_a(15);
      chk(locked, 1'b1, "R11", "spacing count unaffected by idle");
      chk(frame_start, 1'b1, "R10", "pulse on confirmed frame in lock");
   endtask

   task automatic t_strobe_mode();
      do_reset(2'b11, 1'b1, 1'b0);
      zeros(5);
      send_a(15);
      chk(locked, 1'b0, "R2", "pattern ignored in strobe mode");
      send_bit(1'b0, 1'b1);
      chk(locked, 1'b1, "R2", "strobe edge is frame start");
      zeros(FLEN - 1);
      chk(frame_start, 1'b0, "R10", "no pulse between strobes");
      send_bit(1'b0, 1'b1);
      chk(frame_start, 1'b1, "R2", "next strobe confirmed");
      // edge while idle is held for the next valid bit
      zeros(FLEN - 1);
      bit_vld = 1'b0; sync_in = 1'b1;
      @(negedge clk);
      sync_in = 1'b0;
      @(negedge clk);
      send_bit(1'b0, 1'b0);
      chk(frame_start, 1'b1, "R2", "edge during idle applies to next bit");
   endtask

   task automatic t_byte_mode();
      do_reset(2'b10, 1'b1, 1'b0);
      zeros(3);
      for (int i = 0; i < 14; i++) send_bit(pat_s(i), 1'b0);
      chk(locked, 1'b0, "R3", "no candidate before first strobe");
      send_bit(1'b0, 1'b1);
      for (int i = 0; i < 14; i++) send_bit(pat_s(i), 1'b0);
      chk(locked, 1'b0, "R3", "misaligned pattern rejected");
      zeros(6);
      send_bit(pat_s(0), 1'b1);
      for (int i = 1; i < 14; i++) send_bit(pat_s(i), 1'b0);
      chk(locked, 1'b1, "R3", "aligned pattern accepted");
   endtask

   task automatic t_dual_mode();
      // match ends on the timeout bit: judged with the old pattern
      do_reset(2'b00, 1'b1, 1'b0);
      zeros(TMO - 15);
      send_a(15);
      chk(locked, 1'b1, "R5", "match on timeout bit uses old pattern");
      // one bit later: pattern already switched
      do_reset(2'b00, 1'b1, 1'b0);
      zeros(TMO - 14);
      send_a(15);
      chk(locked, 1'b0, "R5", "first pattern not searched after timeout");
      zeros(20);
      send_a(14);
      chk(locked, 1'b1, "R5", "alternate pattern found after timeout");
   endtask

   initial begin
      t_reset();
      t_long_mode();
      t_depth(1'b1, 1'b0, 0);
      t_depth(1'b1, 1'b1, 1);
      t_depth(1'b0, 1'b0, 1);
      t_depth(1'b0, 1'b1, 2);
      t_verify_fail();
      t_loss();
      t_idle();
      t_strobe_mode();
      t_byte_mode();
      t_dual_mode();
      bit_vld = 1'b0;
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule